// File: doc/BRIEF.md
# Edge-Triggered Switch Command Arbiter

This block sits between an upstream controller and the ramp sequencer that drives a mechanical power switch. The controller raises two asynchronous command lines, one asking for the switch to open and one asking for it to close. The block synchronizes both lines, picks out their rising edges and tracks the switch through four phases: closed, opening, open and closing. When an edge calls for movement, it sends a single-cycle request to the ramp sequencer. The sequencer answers with a completion pulse when the actuation ends.

Only rising edges count. A line held high does nothing after its first edge. An edge that asks for the position the switch already holds, or is heading to, is discarded. An edge that asks for the reverse of a movement in progress is held as pending and starts the reverse movement on the cycle the current one completes. When both lines rise in the same cycle, the edge that changes the switch's current or target position takes effect.

Top module: `switch_cmd_arbiter`

## Requirements
- R1: After reset, `swState` reads closed (encoding: 2'b00 closed, 2'b01 opening, 2'b10 open, 2'b11 closing), or open when `INIT_OPEN` is 1, and both request outputs are low.
- R2: In the closed state, a rising edge on `openCmd` moves the state to opening and pulses `openReq`, whatever level `closeCmd` has. A level present at clock edge k acts at clock edge k+SYNC_STAGES, and the request and the new state appear together after that edge.
- R3: In the open state, a rising edge on `closeCmd` moves the state to closing and pulses `closeReq`, whatever level `openCmd` has.
- R4: A close edge while closed, an open edge while open, and command levels that stay high without a new edge cause no state change and no request.
- R5: `actDone` moves opening to open and closing to closed when no reversal is pending. In the closed and open states, `actDone` has no effect.
- R6: An opposite-direction edge during a transition is held. On the following `actDone`, the state goes straight to the reverse transition and the matching request pulses.
- R7: A same-direction edge during a transition cancels any held reversal, and the transition then completes normally.
- R8: When both edges arrive in the same cycle, the state-changing edge wins. In a stable state, the edge that leaves that state acts. In a transition, the reversing edge is held.
- R9: A request is high for exactly one cycle, and `openReq` and `closeReq` are never high together.
- R10: An opposite edge that lands in the same cycle as `actDone` starts the reversal at once. A same-direction edge in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| openCmd | input | 1 | Asynchronous open command line |
| closeCmd | input | 1 | Asynchronous close command line |
| actDone | input | 1 | Single-cycle actuation-complete pulse from the ramp sequencer |
| openReq | output | 1 | Single-cycle request to start an opening ramp |
| closeReq | output | 1 | Single-cycle request to start a closing ramp |
| swState | output | 2 | Switch phase: 00 closed, 01 opening, 10 open, 11 closing |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is the two command edges. The second is a command edge and the completion pulse, and this pair matters more. The bench drives both command lines up on the same clock in the stable states and in the transition states. It also raises a command line exactly SYNC_STAGES cycles before it pulses `actDone`, so that the synchronized edge and the completion are sampled together. The bench judges each case by the resulting `swState` and by which request pulses, and compares these with a cycle-accurate reference model that is driven from the same inputs.

// File: rtl/swarb_pkg.sv
package swarb_pkg;

  typedef enum logic [1:0] {
    ST_CLOSED  = 2'b00,
    ST_OPENING = 2'b01,
    ST_OPEN    = 2'b10,
    ST_CLOSING = 2'b11
  } swState_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic issueOpen;
    logic issueClose;
    logic setPending;
    logic clrPending;
  } ctrlStrobe_t;

  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_OPEN = 0;
  localparam int unsigned LINE_CLOSE = 1;

endpackage

// File: rtl/arb_edge_sync.sv
module arb_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic riseOut
);
  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN-2:0], lineIn};
  end

  // the last synchronizer stage against the history flop
  assign riseOut = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import swarb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        openCmd,
  input  logic        closeCmd,
  input  ctrlStrobe_t strobe,
  output logic        openEdge,
  output logic        closeEdge,
  output logic        pending,
  output logic        openReq,
  output logic        closeReq
);
  logic [NUM_LINES-1:0] lines;
  logic [NUM_LINES-1:0] rises;

  assign lines[LINE_OPEN]  = openCmd;
  assign lines[LINE_CLOSE] = closeCmd;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    arb_edge_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (lines[g]),
      .riseOut(rises[g])
    );
  end

  assign openEdge  = rises[LINE_OPEN];
  assign closeEdge = rises[LINE_CLOSE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      openReq  <= 1'b0;
      closeReq <= 1'b0;
    end else begin
      if (strobe.setPending)      pending <= 1'b1;
      else if (strobe.clrPending) pending <= 1'b0;
      openReq  <= strobe.issueOpen;
      closeReq <= strobe.issueClose;
    end
  end

endmodule

// File: rtl/arb_control.sv
module arb_control
  import swarb_pkg::*;
#(
  parameter bit INIT_OPEN = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        openEdge,
  input  logic        closeEdge,
  input  logic        pending,
  input  logic        actDone,
  output ctrlStrobe_t strobe,
  output swState_e    state
);
  localparam swState_e RESET_STATE = INIT_OPEN ? ST_OPEN : ST_CLOSED;

  swState_e nextState;
  logic     pendEff;

  always_comb begin
    nextState = state;
    strobe    = '0;
    pendEff   = pending;
    unique case (state)
      ST_CLOSED: begin
        if (openEdge) begin
          nextState        = ST_OPENING;
          strobe.issueOpen = 1'b1;
        end
      end
      ST_OPEN: begin
        if (closeEdge) begin
          nextState         = ST_CLOSING;
          strobe.issueClose = 1'b1;
        end
      end
      ST_OPENING: begin
        if (closeEdge)     pendEff = 1'b1;
        else if (openEdge) pendEff = 1'b0;
        if (actDone) begin
          strobe.clrPending = 1'b1;
          if (pendEff) begin
            nextState         = ST_CLOSING;
            strobe.issueClose = 1'b1;
          end else begin
            nextState = ST_OPEN;
          end
        end else begin
          strobe.setPending = pendEff;
          strobe.clrPending = ~pendEff;
        end
      end
      ST_CLOSING: begin
        if (openEdge)       pendEff = 1'b1;
        else if (closeEdge) pendEff = 1'b0;
        if (actDone) begin
          strobe.clrPending = 1'b1;
          if (pendEff) begin
            nextState        = ST_OPENING;
            strobe.issueOpen = 1'b1;
          end else begin
            nextState = ST_CLOSED;
          end
        end else begin
          strobe.setPending = pendEff;
          strobe.clrPending = ~pendEff;
        end
      end
      default: nextState = RESET_STATE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= RESET_STATE;
    else       state <= nextState;
  end

endmodule

// File: rtl/switch_cmd_arbiter.sv
module switch_cmd_arbiter
  import swarb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          INIT_OPEN   = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       openCmd,
  input  logic       closeCmd,
  input  logic       actDone,
  output logic       openReq,
  output logic       closeReq,
  output logic [1:0] swState
);
  ctrlStrobe_t strobe;
  swState_e    state;
  logic        openEdge;
  logic        closeEdge;
  logic        pending;

  arb_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .openCmd  (openCmd),
    .closeCmd (closeCmd),
    .strobe   (strobe),
    .openEdge (openEdge),
    .closeEdge(closeEdge),
    .pending  (pending),
    .openReq  (openReq),
    .closeReq (closeReq)
  );

  arb_control #(.INIT_OPEN(INIT_OPEN)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .openEdge (openEdge),
    .closeEdge(closeEdge),
    .pending  (pending),
    .actDone  (actDone),
    .strobe   (strobe),
    .state    (state)
  );

  assign swState = state;

endmodule

// File: rtl/arb_checker.sv
module arb_checker (
  input logic       clk,
  input logic       rstN,
  input logic       actDone,
  input logic       openReq,
  input logic       closeReq,
  input logic [1:0] swState
);
  assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(openReq && closeReq));

  assert_open_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    openReq |=> !openReq);

  assert_close_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    closeReq |=> !closeReq);

  assert_open_req_state_R2: assert property (@(posedge clk) disable iff (!rstN)
    openReq |-> swState == 2'b01);

  assert_close_req_state_R3: assert property (@(posedge clk) disable iff (!rstN)
    closeReq |-> swState == 2'b11);

  assert_closed_leaves_by_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (swState == 2'b00) |=> (swState == 2'b00 || openReq));

  assert_open_leaves_by_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    (swState == 2'b10) |=> (swState == 2'b10 || closeReq));

  assert_opening_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (swState == 2'b01 && !actDone) |=> swState == 2'b01);

  assert_opening_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (swState == 2'b01 && actDone) |=> (swState == 2'b10 || closeReq));

  assert_closing_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (swState == 2'b11 && actDone) |=> (swState == 2'b00 || openReq));

endmodule

bind switch_cmd_arbiter arb_checker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .actDone (actDone),
  .openReq (openReq),
  .closeReq(closeReq),
  .swState (swState)
);

// File: tb/sim_switch_cmd_arbiter.sv
module sim_switch_cmd_arbiter;
  localparam int unsigned STG = 2;
  localparam logic [1:0] CLOSED = 2'b00, OPENING = 2'b01, OPEN = 2'b10, CLOSING = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic openCmd = 1'b0, closeCmd = 1'b0, actDone = 1'b0;
  logic openReq, closeReq;
  logic [1:0] swState;

  int checks = 0;
  int fails = 0;
  bit modelOn = 1'b0;

  always #2 clk = ~clk;

  switch_cmd_arbiter #(.SYNC_STAGES(STG), .INIT_OPEN(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .openCmd(openCmd), .closeCmd(closeCmd),
    .actDone(actDone), .openReq(openReq), .closeReq(closeReq), .swState(swState)
  );

  // reference model built from the requirements
  logic [STG:0] oHist, cHist;
  logic [1:0] mState;
  logic mPend, mOpenReq, mCloseReq;

  function automatic logic [4:0] stepModel(logic [1:0] st, logic pend, logic oE,
                                           logic cE, logic done);
    // returns {state, pend, openReq, closeReq}
    logic p;
    p = pend;
    case (st)
      CLOSED:  return oE ? {OPENING, 1'b0, 1'b1, 1'b0} : {CLOSED, 1'b0, 2'b00};
      OPEN:    return cE ? {CLOSING, 1'b0, 1'b0, 1'b1} : {OPEN, 1'b0, 2'b00};
      OPENING: begin
        if (cE) p = 1'b1; else if (oE) p = 1'b0;
        if (!done) return {OPENING, p, 2'b00};
        return p ? {CLOSING, 1'b0, 1'b0, 1'b1} : {OPEN, 1'b0, 2'b00};
      end
      default: begin
        if (oE) p = 1'b1; else if (cE) p = 1'b0;
        if (!done) return {CLOSING, p, 2'b00};
        return p ? {OPENING, 1'b0, 1'b1, 1'b0} : {CLOSED, 1'b0, 2'b00};
      end
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oHist <= '0; cHist <= '0;
      mState <= CLOSED; mPend <= 1'b0; mOpenReq <= 1'b0; mCloseReq <= 1'b0;
    end else begin
      logic [4:0] r;
      r = stepModel(mState, mPend, oHist[STG-1] & ~oHist[STG],
                    cHist[STG-1] & ~cHist[STG], actDone);
      {mState, mPend, mOpenReq, mCloseReq} <= r;
      oHist <= {oHist[STG-1:0], openCmd};
      cHist <= {cHist[STG-1:0], closeCmd};
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      checks++;
      if (swState !== mState || openReq !== mOpenReq || closeReq !== mCloseReq) begin
        fails++;
        $display("FAIL R9 model: state/oreq/creq actual %b/%b/%b expected %b/%b/%b",
                 swState, openReq, closeReq, mState, mOpenReq, mCloseReq);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkState(string tag, logic [1:0] exp);
    checks++;
    if (swState !== exp) begin
      fails++;
      $display("FAIL %s: swState actual %b expected %b", tag, swState, exp);
    end
  endtask

  task automatic pulseDone();
    actDone = 1'b1; cyc(1); actDone = 1'b0; cyc(1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    modelOn = 1'b1;
    checkState("R1 reset", CLOSED);
    checks++;
    if (openReq !== 1'b0 || closeReq !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset reqs: actual %b%b expected 00", openReq, closeReq);
    end

    closeCmd = 1'b1; cyc(5); checkState("R4 close edge while closed", CLOSED);
    openCmd = 1'b1;  cyc(5); checkState("R2 open edge with close high", OPENING);
    openCmd = 1'b0; closeCmd = 1'b0; cyc(3);
    pulseDone(); checkState("R5 opening done", OPEN);
    pulseDone(); checkState("R5 done ignored when open", OPEN);
    openCmd = 1'b1; cyc(5); checkState("R4 open edge while open", OPEN);
    closeCmd = 1'b1; cyc(5); checkState("R3 close edge with open high", CLOSING);
    cyc(5); checkState("R4 held levels no action", CLOSING);
    openCmd = 1'b0; closeCmd = 1'b0; cyc(2);

    // reversal held and then cancelled
    openCmd = 1'b1; cyc(4); openCmd = 1'b0;
    closeCmd = 1'b1; cyc(4); closeCmd = 1'b0; cyc(2);
    pulseDone(); checkState("R7 same-direction cancels", CLOSED);

    // reversal executed on completion
    openCmd = 1'b1; cyc(4); openCmd = 1'b0; cyc(1);
    closeCmd = 1'b1; cyc(4); closeCmd = 1'b0; cyc(2);
    checkState("R6 held during opening", OPENING);
    pulseDone(); checkState("R6 reverse on done", CLOSING);
    pulseDone(); checkState("R5 closing done", CLOSED);

    // simultaneous edges
    openCmd = 1'b1; closeCmd = 1'b1; cyc(4);
    checkState("R8 both edges while closed", OPENING);
    openCmd = 1'b0; closeCmd = 1'b0; cyc(2);
    openCmd = 1'b1; closeCmd = 1'b1; cyc(4);
    openCmd = 1'b0; closeCmd = 1'b0; cyc(1);
    pulseDone(); checkState("R8 both edges while opening", CLOSING);
    pulseDone(); checkState("R5 back to closed", CLOSED);

    // edge coincident with completion
    openCmd = 1'b1; cyc(5); openCmd = 1'b0; cyc(2);
    closeCmd = 1'b1; cyc(STG); actDone = 1'b1; cyc(1); actDone = 1'b0;
    checkState("R10 opposite edge with done", CLOSING);
    closeCmd = 1'b0; cyc(2);
    pulseDone(); checkState("R10 reversal completes", CLOSED);
    openCmd = 1'b1; cyc(5); openCmd = 1'b0; cyc(2);
    openCmd = 1'b1; cyc(STG); actDone = 1'b1; cyc(1); actDone = 1'b0;
    checkState("R10 same edge with done", OPEN);
    openCmd = 1'b0; cyc(3);

    // constrained random phase, fixed seed
    void'($urandom(32'h5A17));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) openCmd = ~openCmd;
      if ($urandom_range(0, 5) == 0) closeCmd = ~closeCmd;
      actDone = ($urandom_range(0, 6) == 0);
      cyc(1);
    end
    actDone = 1'b0; cyc(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule